// File: doc/BRIEF.md
# Microcontroller Clock Output Generator

This block produces the clock handed to an external microcontroller. A crystal reference clock is divided by one of seven ratios, or a separate low-frequency oscillator clock is passed through, as chosen by a 3-bit select. A sleep request decides what happens next. The block can switch without glitches to the low-frequency clock. Otherwise it keeps the selected clock running for a programmable number of further cycles and then holds the output low. Leaving sleep brings the selected clock back. A crystal-enabled flag gates every crystal-derived setting.

The select, tail and low-frequency-enable fields are loaded from a simple write port with a strobe. The write port, the sleep request and the crystal flag are all synchronous to the reference clock. All crystal-side logic runs in the reference domain. The low-frequency side has one gating flop clocked on that clock's falling edge. A request/acknowledge handshake with synchronisers couples the two sides, so only one path can drive the output at any time.

Top module: `mco_clkgen`

## Requirements
- R1: After reset the select is 110, the tail code is 00 and low-frequency enable is 0. The output is low while reset is asserted and afterwards runs with a period of 30 reference cycles.
- R2: The select sets the output period in reference cycles: 000 gives 1, 001 gives 2, 010 gives 3, 011 gives 7.5, 100 gives 10, 101 gives 15 and 110 gives 30.
- R3: With select 011, consecutive output periods alternate between 7 and 8 reference cycles.
- R4: Select 111 drives the low-frequency clock to the output, whatever the crystal-enabled flag is.
- R5: While the crystal-enabled flag is 0 and a divided select (000 to 110) is chosen, the output is held low once the current period has ended. It resumes when the flag returns to 1.
- R6: While sleep is requested and low-frequency enable is 1, the output is the low-frequency clock for any select. When sleep is released, the selected divided clock returns.
- R7: When sleep is requested with low-frequency enable 0 and a divided select of ratio 2 or more, the output makes exactly T further rising edges after the first reference edge that samples the request, and then stays low. T is 0, U, 2U and 4U for tail codes 00, 01, 10 and 11, where U is the TAIL_UNIT parameter (default 128).
- R8: The output never shows a high or low pulse shorter than half a reference period. It stops only on a low phase, and the crystal and low-frequency paths are never enabled together.
- R9: Releasing sleep while a tail is still counting cancels the stop, so the output keeps running past T edges. A divider restarted from idle begins with its high phase.
- R10: The configuration fields change only on a cycle where the write strobe is 1. Field values presented without the strobe have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Crystal reference clock |
| clk_lf | input | 1 | Low-frequency oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep command, level, reference domain |
| xtal_en | input | 1 | Crystal running flag; divided settings valid only when 1 |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_sel | input | 3 | Clock select field |
| cfg_tail | input | 2 | Tail length code |
| cfg_lfen | input | 1 | Use the low-frequency clock during sleep |
| mclk_out | output | 1 | Clock to the microcontroller |

## Verification
The bench builds the block with TAIL_UNIT set to 4 and two synchroniser stages. With that unit, all four tail codes finish in a few dozen output periods, so each exact edge count of R7 and the abort of R9 can be reached within a short run. The low-frequency clock in the bench is 100 reference periods long. This keeps the handshake crossings of R4 and R6 short, while the two clocks still have no common edges, so the glitch monitor of R8 also sees the path changeovers.

// File: rtl/mco_pkg.sv
package mco_pkg;
   localparam int SEL_W = 3;
   localparam int PH_W  = 5;

   localparam logic [SEL_W-1:0] SEL_PASS  = 3'b000;
   localparam logic [SEL_W-1:0] SEL_SEVEN = 3'b011;
   localparam logic [SEL_W-1:0] SEL_RESET = 3'b110;
   localparam logic [SEL_W-1:0] SEL_LF    = 3'b111;

   typedef enum logic [1:0] {
      CS_RUN   = 2'd0,
      CS_TAIL  = 2'd1,
      CS_HALT  = 2'd2,
      CS_LFSLP = 2'd3
   } ctl_state_t;

   // shorter phase of a divided period, in reference cycles
   function automatic logic [PH_W-1:0] short_len(input logic [SEL_W-1:0] sel, input logic alt);
      case (sel)
         3'b001:  short_len = 5'd1;
         3'b010:  short_len = 5'd1;
         3'b011:  short_len = alt ? 5'd4 : 5'd3;
         3'b100:  short_len = 5'd5;
         3'b101:  short_len = 5'd7;
         3'b110:  short_len = 5'd15;
         default: short_len = 5'd1;
      endcase
   endfunction

   // longer phase of a divided period, in reference cycles
   function automatic logic [PH_W-1:0] long_len(input logic [SEL_W-1:0] sel, input logic alt);
      case (sel)
         3'b001:  long_len = 5'd1;
         3'b010:  long_len = 5'd2;
         3'b011:  long_len = alt ? 5'd4 : 5'd4;
         3'b100:  long_len = 5'd5;
         3'b101:  long_len = 5'd8;
         3'b110:  long_len = 5'd15;
         default: long_len = 5'd1;
      endcase
   endfunction
endpackage

// File: rtl/mco_sync.sv
module mco_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("mco_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{INIT}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mco_xdiv.sv
module mco_xdiv
   import mco_pkg::*;
#(
   parameter bit LONG_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             xclk,
   output logic             idle,
   output logic             start
);
   logic            active_q, hi_q, pass_q, pass_en_q, alt_q;
   logic [PH_W-1:0] cnt_q, lo_q;
   logic [PH_W-1:0] hi_len_w, lo_len_w;
   logic            boundary;

   // odd ratios: the extra reference cycle goes into the low or high phase
   generate
      if (LONG_LOW) begin : g_long_low
         assign hi_len_w = short_len(sel, alt_q);
         assign lo_len_w = long_len(sel, alt_q);
      end else begin : g_long_high
         assign hi_len_w = long_len(sel, alt_q);
         assign lo_len_w = short_len(sel, alt_q);
      end
   endgenerate

   assign boundary = !active_q || pass_q || (!hi_q && cnt_q == '0);
   assign start    = boundary && run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         hi_q     <= 1'b0;
         pass_q   <= 1'b0;
         alt_q    <= 1'b0;
         cnt_q    <= '0;
         lo_q     <= '0;
      end else if (boundary) begin
         if (run) begin
            active_q <= 1'b1;
            if (sel == SEL_PASS) begin
               pass_q <= 1'b1;
               hi_q   <= 1'b0;
               cnt_q  <= '0;
               alt_q  <= 1'b0;
            end else begin
               pass_q <= 1'b0;
               hi_q   <= 1'b1;
               cnt_q  <= hi_len_w - 1'b1;
               lo_q   <= lo_len_w - 1'b1;
               alt_q  <= (sel == SEL_SEVEN) ? ~alt_q : 1'b0;
            end
         end else begin
            active_q <= 1'b0;
            pass_q   <= 1'b0;
            hi_q     <= 1'b0;
            cnt_q    <= '0;
         end
      end else if (hi_q && cnt_q == '0) begin
         hi_q  <= 1'b0;
         cnt_q <= lo_q;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // undivided mode: gate enable changes only while the reference is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) pass_en_q <= 1'b0;
      else        pass_en_q <= pass_q;
   end

   assign xclk = hi_q | (clk & pass_en_q);
   assign idle = !active_q;

   AST_STOP_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> !$past(hi_q)); // R8
   AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(active_q) && !pass_q) |-> hi_q); // R9
endmodule

// File: rtl/mco_lfgate.sv
module mco_lfgate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_ref,
   input  logic clk_lf,
   input  logic rst_n,
   input  logic req,
   output logic ack,
   output logic lf_tick,
   output logic lfclk
);
   logic req_lf, gate_q, lf_level, lf_level_d;

   mco_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_req_sync (
      .clk(clk_lf), .rst_n(rst_n), .d(req), .q(req_lf));

   always_ff @(negedge clk_lf or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= req_lf;
   end

   assign lfclk = clk_lf & gate_q;

   mco_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_ack_sync (
      .clk(clk_ref), .rst_n(rst_n), .d(gate_q), .q(ack));

   mco_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_level_sync (
      .clk(clk_ref), .rst_n(rst_n), .d(clk_lf), .q(lf_level));

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) lf_level_d <= 1'b0;
      else        lf_level_d <= lf_level;
   end

   assign lf_tick = lf_level && !lf_level_d;

   AST_ACK_RISE_WITH_REQ: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(ack) |-> req); // R8
   AST_ACK_FALL_NO_REQ: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $fell(ack) |-> !req); // R8
endmodule

// File: rtl/mco_ctl.sv
module mco_ctl
   import mco_pkg::*;
#(
   parameter int TAIL_UNIT = 128,
   parameter int CNT_W     = $clog2(TAIL_UNIT * 4 + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             xtal_en,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [1:0]       cfg_tail,
   input  logic             cfg_lfen,
   input  logic             start,
   input  logic             x_idle,
   input  logic             lf_tick,
   input  logic             lf_ack,
   output logic             xrun,
   output logic [SEL_W-1:0] sel_o,
   output logic             lf_req
);
   logic [SEL_W-1:0] sel_q;
   logic [1:0]       tail_q;
   logic             lfen_q;
   ctl_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             lf_req_q;
   logic             want_lf, tail_done, alive, lf_go, tick;

   function automatic logic [CNT_W-1:0] tail_len(input logic [1:0] code);
      case (code)
         2'd0:    tail_len = '0;
         2'd1:    tail_len = CNT_W'(TAIL_UNIT);
         2'd2:    tail_len = CNT_W'(TAIL_UNIT * 2);
         default: tail_len = CNT_W'(TAIL_UNIT * 4);
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= SEL_RESET;
         tail_q <= 2'b00;
         lfen_q <= 1'b0;
      end else if (cfg_we) begin
         sel_q  <= cfg_sel;
         tail_q <= cfg_tail;
         lfen_q <= cfg_lfen;
      end
   end

   assign want_lf   = (state_q == CS_LFSLP) || (sel_q == SEL_LF);
   assign tail_done = (state_q == CS_TAIL) && (cnt_q == '0);
   assign alive     = (state_q != CS_HALT) && !tail_done;
   assign lf_go     = want_lf && alive;
   assign xrun      = alive && !want_lf && xtal_en && !lf_req_q && !lf_ack;
   assign tick      = want_lf ? (lf_tick && lf_ack) : start;
   assign sel_o     = sel_q;
   assign lf_req    = lf_req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CS_RUN;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            CS_RUN: if (sleep_req) begin
               if (lfen_q)               state_q <= CS_LFSLP;
               else if (tail_q == 2'b00) state_q <= CS_HALT;
               else begin
                  state_q <= CS_TAIL;
                  cnt_q   <= tail_len(tail_q);
               end
            end
            CS_TAIL: if (!sleep_req)               state_q <= CS_RUN;
                     else if (cnt_q == '0)         state_q <= CS_HALT;
                     else if (tick)                cnt_q   <= cnt_q - 1'b1;
            CS_HALT:  if (!sleep_req) state_q <= CS_RUN;
            default:  if (!sleep_req) state_q <= CS_RUN;
         endcase
      end
   end

   // four-phase request: raised only with the divider idle, dropped only once acknowledged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     lf_req_q <= 1'b0;
      else if (!lf_req_q && lf_go && x_idle && !lf_ack) lf_req_q <= 1'b1;
      else if (lf_req_q && !lf_go && lf_ack)          lf_req_q <= 1'b0;
   end

   AST_LF_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CS_RUN && sleep_req && lfen_q) |=> state_q == CS_LFSLP); // R6
   AST_XTAL_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      !xtal_en |-> !start); // R5
   AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CS_TAIL && sleep_req && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R7
   AST_WAKE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != CS_RUN && !sleep_req) |=> state_q == CS_RUN); // R9
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(sel_q) && $stable(tail_q) && $stable(lfen_q)); // R10
endmodule

// File: rtl/mco_clkgen.sv
module mco_clkgen
   import mco_pkg::*;
#(
   parameter int TAIL_UNIT   = 128,
   parameter int SYNC_STAGES = 2,
   parameter bit LONG_LOW    = 1'b1
) (
   input  logic       clk_ref,
   input  logic       clk_lf,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       xtal_en,
   input  logic       cfg_we,
   input  logic [2:0] cfg_sel,
   input  logic [1:0] cfg_tail,
   input  logic       cfg_lfen,
   output logic       mclk_out
);
   localparam int CNT_W = $clog2(TAIL_UNIT * 4 + 1);

   generate
      if (TAIL_UNIT < 1) begin : g_bad_unit
         $error("mco_clkgen: TAIL_UNIT must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mco_clkgen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             xrun, x_idle, x_start, xclk;
   logic             lf_req, lf_ack, lf_tick, lfclk;
   logic [SEL_W-1:0] sel_w;

   mco_ctl #(.TAIL_UNIT(TAIL_UNIT), .CNT_W(CNT_W)) u_ctl (
      .clk(clk_ref), .rst_n(rst_n), .sleep_req(sleep_req), .xtal_en(xtal_en),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_tail(cfg_tail), .cfg_lfen(cfg_lfen),
      .start(x_start), .x_idle(x_idle), .lf_tick(lf_tick), .lf_ack(lf_ack),
      .xrun(xrun), .sel_o(sel_w), .lf_req(lf_req));

   mco_xdiv #(.LONG_LOW(LONG_LOW)) u_xdiv (
      .clk(clk_ref), .rst_n(rst_n), .run(xrun), .sel(sel_w),
      .xclk(xclk), .idle(x_idle), .start(x_start));

   mco_lfgate #(.SYNC_STAGES(SYNC_STAGES)) u_lfgate (
      .clk_ref(clk_ref), .clk_lf(clk_lf), .rst_n(rst_n), .req(lf_req),
      .ack(lf_ack), .lf_tick(lf_tick), .lfclk(lfclk));

   assign mclk_out = xclk | lfclk;

   AST_PATHS_EXCLUSIVE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !(!x_idle && lf_ack)); // R8
endmodule

// File: tb/mco_clkgen_test.sv
module mco_clkgen_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int TU = 4;

   typedef struct {
      int    span;
      string tag;
   } item_t;

   logic       clk_ref = 1'b0, clk_lf = 1'b0, rst_n = 1'b0;
   logic       sleep_req = 1'b0, xtal_en = 1'b1, cfg_we = 1'b0, cfg_lfen = 1'b0;
   logic [2:0] cfg_sel = 3'b110;
   logic [1:0] cfg_tail = 2'b00;
   logic       mclk_out;

   int      checks = 0, fails = 0, rises = 0, glitches = 0;
   bit      mon_on = 1'b0;
   realtime last_edge = 0.0;
   item_t   sbq[$];

   always #10 clk_ref = ~clk_ref;           // 50 MHz reference
   initial begin #7; forever #1000 clk_lf = ~clk_lf; end

   mco_clkgen #(.TAIL_UNIT(TU), .SYNC_STAGES(2)) uut (
      .clk_ref(clk_ref), .clk_lf(clk_lf), .rst_n(rst_n), .sleep_req(sleep_req),
      .xtal_en(xtal_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_tail(cfg_tail),
      .cfg_lfen(cfg_lfen), .mclk_out(mclk_out));

   always @(posedge mclk_out) rises++;

   always @(mclk_out) begin
      if (mon_on && ($realtime - last_edge) < 9.0) glitches++;
      last_edge = $realtime;
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // monitor: measures two full output periods for each queued expectation
   initial begin
      forever begin
         realtime t0;
         wait (sbq.size() != 0);
         @(posedge mclk_out);
         t0 = $realtime;
         @(posedge mclk_out);
         @(posedge mclk_out);
         chk(sbq[0].tag, int'($realtime - t0), sbq[0].span);
         void'(sbq.pop_front());
      end
   end

   task automatic expect_span(int span, string tag);
      item_t it;
      it.span = span;
      it.tag  = tag;
      sbq.push_back(it);
      wait (sbq.size() == 0);
   endtask

   task automatic write_cfg(logic [2:0] s, logic [1:0] t, logic l);
      @(negedge clk_ref);
      cfg_sel = s; cfg_tail = t; cfg_lfen = l; cfg_we = 1'b1;
      @(negedge clk_ref);
      cfg_we = 1'b0;
   endtask

   task automatic run_tail(logic [1:0] code, int n);
      int base;
      write_cfg(3'b110, code, 1'b0);
      #3000;
      @(negedge clk_ref) sleep_req = 1'b1;
      @(posedge clk_ref);
      #1;
      base = rises;
      #((n + 3) * 600 + 2000);
      chk($sformatf("R7 tail code %0d edges", code), rises - base, n);
      chk($sformatf("R7 tail code %0d output parked low", code), int'(mclk_out), 0);
      @(negedge clk_ref) sleep_req = 1'b0;
      #3000;
   endtask

   initial begin
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      int spans[7] = '{40, 80, 120, 300, 400, 600, 1200};
      realtime t0, t1, t2;
      int p1, p2, base;

      repeat (5) @(negedge clk_ref);
      chk("R1 output low in reset", int'(mclk_out), 0);
      rst_n = 1'b1;
      #500;
      mon_on = 1'b1;
      #1500;
      expect_span(1200, "R1 reset select divides by 30");

      @(negedge clk_ref) cfg_sel = 3'b000;           // no strobe
      #2000;
      expect_span(1200, "R10 fields without strobe ignored");

      for (int s = 0; s < 7; s++) begin
         write_cfg(3'(s), 2'b00, 1'b0);
         #3000;
         expect_span(spans[s], $sformatf("R2 select %0d", s));
      end

      write_cfg(3'b011, 2'b00, 1'b0);
      #2000;
      @(posedge mclk_out) t0 = $realtime;
      @(posedge mclk_out) t1 = $realtime;
      @(posedge mclk_out) t2 = $realtime;
      p1 = int'(t1 - t0);
      p2 = int'(t2 - t1);
      chk("R3 alternating 7/8 periods",
          int'(((p1 == 140 && p2 == 160) || (p1 == 160 && p2 == 140))), 1);

      write_cfg(3'b111, 2'b00, 1'b0);
      @(negedge clk_ref) xtal_en = 1'b0;
      #10000;
      expect_span(4000, "R4 low-frequency select with crystal off");
      @(negedge clk_ref) xtal_en = 1'b1;

      write_cfg(3'b010, 2'b00, 1'b0);
      #10000;
      @(negedge clk_ref) xtal_en = 1'b0;
      #1000;
      base = rises;
      #3000;
      chk("R5 no edges with crystal off", rises - base, 0);
      chk("R5 output held low", int'(mclk_out), 0);
      @(negedge clk_ref) xtal_en = 1'b1;
      #2000;
      expect_span(120, "R5 resumes with crystal on");

      write_cfg(3'b000, 2'b00, 1'b1);
      #2000;
      @(negedge clk_ref) sleep_req = 1'b1;
      #10000;
      expect_span(4000, "R6 low-frequency clock in sleep");
      @(negedge clk_ref) sleep_req = 1'b0;
      #10000;
      expect_span(40, "R6 selected clock after wake");

      run_tail(2'b00, 0);
      run_tail(2'b01, TU);
      run_tail(2'b10, 2 * TU);
      run_tail(2'b11, 4 * TU);

      write_cfg(3'b110, 2'b11, 1'b0);
      #3000;
      @(negedge clk_ref) sleep_req = 1'b1;
      @(posedge clk_ref);
      #1;
      base = rises;
      #(3 * 600 + 100);
      @(negedge clk_ref) sleep_req = 1'b0;
      #(24 * 600);
      chk("R9 wake cancels tail", int'((rises - base) > 4 * TU), 1);
      expect_span(1200, "R9 period after cancelled tail");

      chk("R8 no short pulses", glitches, 0);

      summary();
      $finish;
   end
endmodule